// File: doc/BRIEF.md
# Expansion-ROM window ownership tracker

Several peripheral cards can share one 2 KiB expansion-ROM window at $C800-$CFFF. Each card keeps a single ownership bit that says whether it currently answers reads in that window. This block is that per-card logic for a card in a slot chosen by a parameter. Any access to the card's own slot page ($Csxx) sets the bit. Any access to $CFFF drops it.

The block runs on a fast logic clock, roughly 54 MHz, so several logic edges fall inside one bus phase. The address bus can carry transients between phases while other drivers switch off. For that reason, address decoding changes state only while phi0 is high.

The read enable needs all of the following:
- the ownership bit is set;
- the internal-ROM override is clear;
- the most recently accessed slot number equals this card's slot;
- the address is in the window;
- the cycle is a read during phi0.

The slot-number check keeps a stale ownership bit from driving the shared data path after another slot's page has been touched. ROM storage sits outside the block.

Top module: `xrom_owner`

## Requirements
- R1: While reset is asserted, and until the synchronised release, `own_o` is 0 and `rom_en_o` is 0.
- R2: An access (read or write) with phi0 high to any address whose upper byte is 0xC0 plus the slot number (0xC2 for the default slot 2) sets `own_o` at the next logic clock edge.
- R3: An access with phi0 high to address 0xCFFF clears `own_o` at the next logic clock edge. A read of 0xCFFF that meets R5-R7 is still enabled in the cycle it is presented.
- R4: While phi0 is low, no address value changes `own_o`, including 0xCFFF and the card's own page.
- R5: `rom_en_o` is 1 only while `own_o` is 1 and `int_rom_i` is 0.
- R6: `rom_en_o` is 1 only while `last_slot_i` equals the card's slot number. A set `own_o` with a different last slot gives no enable.
- R7: `rom_en_o` is 1 only for addresses 0xC800-0xCFFF, with `rd_i` at 1 and phi0 high. It follows the current address combinationally.
- R8: Accesses with phi0 high to any page other than the card's slot page leave `own_o` unchanged, except the single address 0xCFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast logic clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phi0_i | input | 1 | Bus phase qualifier; high while the address is valid |
| rd_i | input | 1 | 1 for a read cycle |
| addr_i | input | 16 | Bus address |
| int_rom_i | input | 1 | Internal-ROM override; 1 blocks the card's window |
| last_slot_i | input | 3 | Slot number of the most recent slot-page access |
| own_o | output | 1 | Ownership bit for the expansion window |
| rom_en_o | output | 1 | Card may drive data for this window read |

## Verification
The bench walks all 256 address pages with phi0 high and again with phi0 low. A decoder that matched too wide a page range would claim ownership from a neighbour slot. A design without phi0 gating would drop ownership on a $CFFF transient. The enable is swept across every slot number, override value, read/write and phase at the window edges ($C7FF, $C800, $CFFE, $D000). A missing slot guard shows up there as a stale enable, and an off-by-one window decode shows up at the edges. A read of $CFFF while owning checks that the enable is granted that cycle and the bit is gone on the next one.

// File: rtl/xrom_pkg.sv
package xrom_pkg;
  localparam int ADDR_W   = 16;
  localparam int PAGE_W   = 8;
  localparam logic [ADDR_W-1:0] RELEASE_ADDR = 16'hCFFF;
  localparam logic [4:0]        WINDOW_TAG   = 5'b11001;   // $C800-$CFFF

  typedef struct packed {
    logic own_page;
    logic release_hit;
    logic in_window;
  } xrom_hits_t;

  function automatic logic [PAGE_W-1:0] slot_page(input int slot);
    return 8'hC0 | PAGE_W'(slot);
  endfunction
endpackage

// File: rtl/xrom_rst_sync.sv
module xrom_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/xrom_decode.sv
module xrom_decode
  import xrom_pkg::*;
#(
  parameter int SLOT_ID = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output xrom_hits_t        hits_o
);
  localparam logic [PAGE_W-1:0] OwnPage = slot_page(SLOT_ID);

  always_comb begin
    hits_o.own_page    = (addr_i[ADDR_W-1 -: PAGE_W] == OwnPage);
    hits_o.release_hit = (addr_i == RELEASE_ADDR);
    hits_o.in_window   = (addr_i[ADDR_W-1 -: 5] == WINDOW_TAG);
  end
endmodule

// File: rtl/xrom_own_reg.sv
module xrom_own_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phase_i,
  input  logic set_i,
  input  logic clr_i,
  output logic own_o
);
  logic own_q, own_d, own_en;

  // next state: release wins over claim
  always_comb begin
    own_en = phase_i & (set_i | clr_i);
    own_d  = ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     own_q <= 1'b0;
    else if (own_en) own_q <= own_d;
  end

  assign own_o = own_q;
endmodule

// File: rtl/xrom_owner.sv
module xrom_owner
  import xrom_pkg::*;
#(
  parameter int SLOT_ID = 2,
  parameter int SLOT_W  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phi0_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              int_rom_i,
  input  logic [SLOT_W-1:0] last_slot_i,
  output logic              own_o,
  output logic              rom_en_o
);
  localparam logic [SLOT_W-1:0] MySlot = SLOT_W'(SLOT_ID);

  logic       rst_n_sync;
  xrom_hits_t hits;
  logic       slot_match;

  xrom_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_n_sync)
  );

  xrom_decode #(.SLOT_ID(SLOT_ID)) u_dec (
    .addr_i(addr_i),
    .hits_o(hits)
  );

  xrom_own_reg u_own (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .phase_i(phi0_i),
    .set_i  (hits.own_page),
    .clr_i  (hits.release_hit),
    .own_o  (own_o)
  );

  always_comb begin
    slot_match = (last_slot_i == MySlot);
    rom_en_o   = own_o & ~int_rom_i & slot_match & hits.in_window & phi0_i & rd_i;
  end
endmodule

// File: rtl/xrom_owner_chk.sv
module xrom_owner_chk #(
  parameter int SLOT_ID = 2,
  parameter int SLOT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_n_sync,
  input logic              phi0_i,
  input logic              rd_i,
  input logic [15:0]       addr_i,
  input logic              int_rom_i,
  input logic [SLOT_W-1:0] last_slot_i,
  input logic              own_o,
  input logic              rom_en_o
);
  localparam logic [7:0] PageHi = 8'hC0 | 8'(SLOT_ID);

  always_comb begin
    if (!rst_n_sync) AST_RESET_CLEAR: assert (!own_o && !rom_en_o); // R1
  end

  AST_CLAIM_ON_PAGE: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (phi0_i && addr_i[15:8] == PageHi) |=> own_o); // R2
  AST_RELEASE_CFFF: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (phi0_i && addr_i == 16'hCFFF) |=> !own_o); // R3
  AST_HOLD_OFF_PHASE: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    !phi0_i |=> $stable(own_o)); // R4
  AST_EN_NEEDS_OWN: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    rom_en_o |-> (own_o && !int_rom_i)); // R5
  AST_EN_NEEDS_SLOT: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    rom_en_o |-> (last_slot_i == SLOT_W'(SLOT_ID))); // R6
  AST_EN_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    rom_en_o |-> (addr_i[15:11] == 5'b11001 && rd_i && phi0_i)); // R7
  AST_OTHER_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (addr_i[15:8] != PageHi && addr_i != 16'hCFFF) |=> $stable(own_o)); // R8
endmodule

bind xrom_owner xrom_owner_chk #(.SLOT_ID(SLOT_ID), .SLOT_W(SLOT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n_sync (rst_n_sync),
  .phi0_i     (phi0_i),
  .rd_i       (rd_i),
  .addr_i     (addr_i),
  .int_rom_i  (int_rom_i),
  .last_slot_i(last_slot_i),
  .own_o      (own_o),
  .rom_en_o   (rom_en_o)
);

// File: tb/tb_xrom_owner.sv
module tb_xrom_owner;
  localparam int SLOT = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni, phi0_i, rd_i, int_rom_i;
  logic [15:0] addr_i;
  logic [2:0]  last_slot_i;
  logic        own_o, rom_en_o;

  int checks = 0;
  int fails  = 0;
  logic exp_own = 1'b0;

  always #2 clk_i = ~clk_i;

  xrom_owner dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .phi0_i(phi0_i), .rd_i(rd_i),
    .addr_i(addr_i), .int_rom_i(int_rom_i), .last_slot_i(last_slot_i),
    .own_o(own_o), .rom_en_o(rom_en_o)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  // one logic cycle: drive at negedge, check enable mid-cycle, check flag after edge
  task automatic step(input logic [15:0] a, input logic r, input logic p,
                      input logic ir, input logic [2:0] s, input string tag);
    logic exp_en;
    @(negedge clk_i);
    addr_i = a; rd_i = r; phi0_i = p; int_rom_i = ir; last_slot_i = s;
    #1;
    exp_en = exp_own && !ir && (s == 3'(SLOT)) && (a >= 16'hC800) && (a <= 16'hCFFF) && p && r;
    check(rom_en_o, exp_en, {tag, " en"});
    @(posedge clk_i);
    if (p) begin
      if (a == 16'hCFFF) exp_own = 1'b0;
      else if (a[15:8] == (8'hC0 | 8'(SLOT))) exp_own = 1'b1;
    end
    #1;
    check(own_o, exp_own, {tag, " own"});
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; phi0_i = 1'b1; rd_i = 1'b1; int_rom_i = 1'b0;
    last_slot_i = 3'(SLOT); addr_i = 16'hC200;
    repeat (3) @(negedge clk_i);
    #1;
    check(own_o, 1'b0, "R1 own in reset");
    check(rom_en_o, 1'b0, "R1 en in reset");
    @(negedge clk_i);
    addr_i = 16'h0000;
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(own_o, 1'b0, "R1 own after release");

    // page sweep with phi0 high: R2 own page claims, R8 others do not
    for (int p = 0; p < 256; p++) begin
      step(16'hCFFF, 1'b0, 1'b1, 1'b0, 3'(SLOT), "R3 release");
      step({8'(p), 8'h40}, p[0], 1'b1, 1'b0, 3'(SLOT),
           (p == (8'hC0 | SLOT)) ? "R2 claim" : "R8 other page");
      step({8'(p), 8'h40}, 1'b0, 1'b1, 1'b0, 3'(SLOT), "R8 hold");
    end

    // phi0 low sweep while owning and while not owning: R4
    step(16'hC2FF, 1'b1, 1'b1, 1'b0, 3'(SLOT), "R2 claim");
    for (int p = 0; p < 256; p++)
      step({8'(p), 8'hFF}, 1'b1, 1'b0, 1'b0, 3'(SLOT), "R4 owned, phi0 low");
    step(16'hCFFF, 1'b1, 1'b1, 1'b0, 3'(SLOT), "R3 read release");
    for (int p = 0; p < 256; p++)
      step({8'(p), 8'h00}, 1'b0, 1'b0, 1'b0, 3'(SLOT), "R4 idle, phi0 low");

    // enable sweep while owning: R5 override, R6 slot, R7 window/read/phase
    step(16'hC210, 1'b0, 1'b1, 1'b0, 3'(SLOT), "R2 claim");
    for (int ir = 0; ir < 2; ir++)
      for (int s = 0; s < 8; s++)
        for (int rp = 0; rp < 4; rp++)
          for (int k = 0; k < 5; k++) begin
            logic [15:0] a;
            case (k)
              0: a = 16'hC7FF;
              1: a = 16'hC800;
              2: a = 16'hCC00;
              3: a = 16'hCFFE;
              default: a = 16'hD000;
            endcase
            step(a, rp[0], rp[1], ir[0], 3'(s),
                 ir[0] ? "R5 override" : ((s != SLOT) ? "R6 slot" : "R7 window"));
          end

    // read of release address while owning: enabled now, released after
    step(16'hCFFF, 1'b1, 1'b1, 1'b0, 3'(SLOT), "R3 enabled then released");
    step(16'hC900, 1'b1, 1'b1, 1'b0, 3'(SLOT), "R5 no enable after release");

    // stale ownership with another slot touched later: R6
    step(16'hC2AA, 1'b1, 1'b1, 1'b0, 3'(SLOT), "R2 claim");
    step(16'hC3AA, 1'b1, 1'b1, 1'b0, 3'd3, "R8 neighbour page");
    step(16'hCA00, 1'b1, 1'b1, 1'b0, 3'd3, "R6 stale owner");
    step(16'hCA00, 1'b1, 1'b1, 1'b0, 3'(SLOT), "R7 back to own slot");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule